// File: doc/BRIEF.md
# Hundredths Stopwatch with Lap Freeze and Clear

This block is a decimal stopwatch that counts hundredths of a second and drives one seven-segment pattern per digit. Its system clock is 4096 Hz, which is not a whole multiple of 100 Hz. A fractional accumulator therefore spreads the hundredth ticks over the clock cycles so that exactly `TICK_HZ` ticks come out per `CLK_HZ` cycles of running time. The count is held in cascaded BCD digits. It wraps from all nines back to zero.

Two push-button inputs control it. Both rest low and are acted on once per rising edge. The start key toggles between running and stopped. The lap key has two roles. While running, it freezes the display on the value shown at the press and counting continues behind it; a second press brings the live count back. While stopped, it clears the time and the fractional residue and also leaves the frozen view.

The control machine has four states. `SW_IDLE` is stopped with the live view. `SW_RUN` is running with the live view. `SW_RUN_FROZEN` is running with the lap view. `SW_IDLE_FROZEN` is stopped with the lap view. The transitions are:
- A start press moves `SW_IDLE` to `SW_RUN`, `SW_RUN` to `SW_IDLE`, `SW_RUN_FROZEN` to `SW_IDLE_FROZEN`, and `SW_IDLE_FROZEN` to `SW_RUN_FROZEN`.
- A lap press moves `SW_RUN` to `SW_RUN_FROZEN` and captures the shown value. It moves `SW_RUN_FROZEN` back to `SW_RUN`.
- A lap press in `SW_IDLE` or `SW_IDLE_FROZEN` clears the time and ends in `SW_IDLE`.

Top module: `sw_stopwatch`

## Requirements
- R1: After a synchronous active-high `rst`, the block is in `SW_IDLE` and every digit shows 0. With no key pressed, the display stays at 0.
- R2: Each digit is encoded on 7 bits, bit 6 down to bit 0, as follows: 0=1111110, 1=1100000, 2=1011011, 3=1110011, 4=1100101, 5=0110111, 6=0111111, 7=1100010, 8=1111111, 9=1110111. A digit value above 9 gives 0000000. Digit i (i=0 counts hundredths) occupies `seg_o[7*i+6 : 7*i]`.
- R3: Starting from a cleared time, after N clock edges in a running state the count equals floor(N*TICK_HZ/CLK_HZ). The first running edge is the edge after the start press.
- R4: The start key toggles between running and stopped once per rising edge. Holding it high for any number of cycles acts only once.
- R5: Stopping holds the count and the fractional residue. Later run intervals add to the held time.
- R6: A lap press while running freezes the display on the value shown in the cycle of the press, while the count keeps advancing. The next lap press while running shows the live count again.
- R7: A lap press while stopped sets the count and residue to zero and leaves the frozen view. The display reads 0 in the cycle after the press.
- R8: A start press while frozen keeps the frozen view in both the stopped and the running states.
- R9: When both keys rise on the same edge, only the start key acts. The lap press is ignored: no freeze, no unfreeze, no clear.
- R10: The count wraps from 10^DIGITS-1 to 0 on the next tick.
- R11: Each digit runs 0 to 9. A digit carries into the next digit when it wraps from 9 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally CLK_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| key_start | input | 1 | Run/stop key, high while pressed |
| key_lap | input | 1 | Lap-freeze / clear key, high while pressed |
| seg_o | output | 7*DIGITS | Segment patterns, 7 bits per digit, hundredths digit lowest |

## Verification
Two kinds of events can land on the same edge. A key press can coincide with a hundredth tick, and a start press can coincide with a lap press. The bench uses a tick ratio of 3 per 7 cycles, so presses fall on tick and non-tick edges alike. There it checks that a lap capture shows the pre-tick value and that a stop on a tick edge still counts that tick. It also raises both keys together while running and confirms through the display that only the run state changed and the lap view did not toggle. Every cycle is compared against an arithmetic model of the count, and the run continues through the full wrap.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        SW_IDLE        = 2'd0,
        SW_RUN         = 2'd1,
        SW_RUN_FROZEN  = 2'd2,
        SW_IDLE_FROZEN = 2'd3
    } sw_state_e;

    // R2: digit to segment pattern, bit 6 first
    function automatic logic [6:0] seg_of(input logic [3:0] d);
        logic [6:0] s;
        unique case (d)
            4'd0:    s = 7'b1111110;
            4'd1:    s = 7'b1100000;
            4'd2:    s = 7'b1011011;
            4'd3:    s = 7'b1110011;
            4'd4:    s = 7'b1100101;
            4'd5:    s = 7'b0110111;
            4'd6:    s = 7'b0111111;
            4'd7:    s = 7'b1100010;
            4'd8:    s = 7'b1111111;
            4'd9:    s = 7'b1110111;
            default: s = 7'b0000000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sw_key_edge.sv
module sw_key_edge (
    input  logic clk,
    input  logic rst,
    input  logic key,
    output logic press
);
    logic key_q;

    always_ff @(posedge clk) begin
        if (rst) key_q <= 1'b0;
        else     key_q <= key;
    end

    assign press = key & ~key_q;

    // R4: a held key yields a single press
    assert_single_press_R4: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);
endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
    parameter int CLK_HZ  = 4096,
    parameter int TICK_HZ = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ + 1);
    localparam logic [ACC_W-1:0] STEP  = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    assign sum  = acc_q + STEP;
    assign tick = en && !clr && (sum >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clr)   acc_q <= '0;
        else if (en)      acc_q <= (sum >= LIMIT) ? sum - LIMIT : sum;
    end

    // R3: residue stays below one clock period's worth
    assert_acc_range_R3: assert property (@(posedge clk) disable iff (rst)
        acc_q < LIMIT);
    // R5: residue held while stopped
    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/sw_bcd_chain.sv
module sw_bcd_chain #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  tick,
    output logic [DIGITS*4-1:0]   bcd
);
    localparam logic [DIGITS*4-1:0] ALL_NINE = {DIGITS{4'd9}};

    logic [DIGITS:0] carry;
    assign carry[0] = tick;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] d_q;
        assign carry[i+1] = carry[i] && (d_q == 4'd9);
        assign bcd[i*4 +: 4] = d_q;

        always_ff @(posedge clk) begin
            if (rst || clr)    d_q <= 4'd0;
            else if (carry[i]) d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
        end

        // R11: each digit stays decimal
        assert_digit_bcd_R11: assert property (@(posedge clk) disable iff (rst)
            d_q <= 4'd9);
    end

    // R10: full-scale wraps to zero
    assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && bcd == ALL_NINE) |=> (bcd == '0));
endmodule

// File: rtl/sw_seg_encoder.sv
module sw_seg_encoder #(
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*4-1:0] bcd,
    output logic [DIGITS*7-1:0] seg
);
    for (genvar i = 0; i < DIGITS; i++) begin : g_enc
        assign seg[i*7 +: 7] = sw_pkg::seg_of(bcd[i*4 +: 4]);
    end
endmodule

// File: rtl/sw_stopwatch.sv
module sw_stopwatch #(
    parameter int CLK_HZ  = 4096,
    parameter int TICK_HZ = 100,
    parameter int DIGITS  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_start,
    input  logic                key_lap,
    output logic [DIGITS*7-1:0] seg_o
);
    import sw_pkg::*;

    localparam int BCD_W = DIGITS * 4;

    sw_state_e state_q, state_d;
    logic start_p, lap_raw, lap_p;
    logic count_en, clr, capture, show_frozen;
    logic tick;
    logic [BCD_W-1:0] count_bcd, frozen_q, shown;

    sw_key_edge u_key_start (.clk(clk), .rst(rst), .key(key_start), .press(start_p));
    sw_key_edge u_key_lap   (.clk(clk), .rst(rst), .key(key_lap),   .press(lap_raw));

    // R9: start wins a tie
    assign lap_p = lap_raw & ~start_p;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: begin
                if (start_p)    state_d = SW_RUN;
            end
            SW_RUN: begin
                if (start_p)    state_d = SW_IDLE;
                else if (lap_p) state_d = SW_RUN_FROZEN;
            end
            SW_RUN_FROZEN: begin
                if (start_p)    state_d = SW_IDLE_FROZEN;
                else if (lap_p) state_d = SW_RUN;
            end
            SW_IDLE_FROZEN: begin
                if (start_p)    state_d = SW_RUN_FROZEN;
                else if (lap_p) state_d = SW_IDLE;
            end
            default:            state_d = SW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SW_IDLE;
        else     state_q <= state_d;
    end

    // outputs of the machine
    always_comb begin
        count_en    = 1'b0;
        clr         = 1'b0;
        capture     = 1'b0;
        show_frozen = 1'b0;
        unique case (state_q)
            SW_IDLE: begin
                clr = lap_p;
            end
            SW_RUN: begin
                count_en = 1'b1;
                capture  = lap_p;
            end
            SW_RUN_FROZEN: begin
                count_en    = 1'b1;
                show_frozen = 1'b1;
            end
            SW_IDLE_FROZEN: begin
                clr         = lap_p;
                show_frozen = 1'b1;
            end
            default: ;
        endcase
    end

    sw_prescaler #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_pre (
        .clk(clk), .rst(rst), .en(count_en), .clr(clr), .tick(tick)
    );

    sw_bcd_chain #(.DIGITS(DIGITS)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .tick(tick), .bcd(count_bcd)
    );

    always_ff @(posedge clk) begin
        if (rst)          frozen_q <= '0;
        else if (capture) frozen_q <= count_bcd;
    end

    assign shown = show_frozen ? frozen_q : count_bcd;

    sw_seg_encoder #(.DIGITS(DIGITS)) u_enc (.bcd(shown), .seg(seg_o));

    // R6 / R8: frozen view holds until a lap press
    assert_lap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (show_frozen && !lap_p) |=> $stable(seg_o));
    // R7: stopped lap press clears and leaves frozen view
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (!count_en && lap_p) |=> (count_bcd == '0 && !show_frozen));
    // R9: tie does not change the view mode
    assert_start_priority_R9: assert property (@(posedge clk) disable iff (rst)
        (start_p && lap_raw) |=> (show_frozen == $past(show_frozen)));
    // R1: no count advance while stopped without a press
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !lap_p) |=> $stable(count_bcd));
endmodule

// File: tb/tb_sw_stopwatch.sv
module tb_sw_stopwatch;
    localparam int CLK_HZ  = 7;
    localparam int TICK_HZ = 3;
    localparam int DIGITS  = 4;
    localparam int MODV    = 10 ** DIGITS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_start = 1'b0;
    logic key_lap = 1'b0;
    logic [DIGITS*7-1:0] seg_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    bit m_run, m_lap, p1, p2;
    int m_cnt, m_acc, m_frz;

    sw_stopwatch #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .DIGITS(DIGITS)) dut (
        .clk(clk), .rst(rst), .key_start(key_start), .key_lap(key_lap), .seg_o(seg_o)
    );

    always #5 clk = ~clk;

    function automatic logic [6:0] code7(input int d);
        case (d)
            0: return 7'b1111110;
            1: return 7'b1100000;
            2: return 7'b1011011;
            3: return 7'b1110011;
            4: return 7'b1100101;
            5: return 7'b0110111;
            6: return 7'b0111111;
            7: return 7'b1100010;
            8: return 7'b1111111;
            9: return 7'b1110111;
            default: return 7'b0000000;
        endcase
    endfunction

    function automatic logic [DIGITS*7-1:0] pattern(input int v);
        logic [DIGITS*7-1:0] r;
        int x = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[i*7 +: 7] = code7(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic model_reset();
        m_run = 0; m_lap = 0; p1 = 0; p2 = 0;
        m_cnt = 0; m_acc = 0; m_frz = 0;
    endtask

    task automatic model_edge(input bit k1, input bit k2);
        bit pr1, pr2, o_run, o_lap;
        int o_cnt;
        pr1 = k1 && !p1;
        pr2 = k2 && !p2 && !pr1;           // R9
        o_run = m_run; o_lap = m_lap; o_cnt = m_cnt;
        if (o_run) begin                    // R3
            if (m_acc + TICK_HZ >= CLK_HZ) begin
                m_acc = m_acc + TICK_HZ - CLK_HZ;
                m_cnt = (m_cnt + 1) % MODV;   // R10
            end else m_acc = m_acc + TICK_HZ;
        end
        if (pr2 && !o_run) begin m_cnt = 0; m_acc = 0; m_lap = 0; end   // R7
        if (pr2 && o_run) begin                                          // R6
            if (!o_lap) m_frz = o_cnt;
            m_lap = !o_lap;
        end
        if (pr1) m_run = !o_run;           // R4, R8
        p1 = k1; p2 = k2;
    endtask

    task automatic check_val(input int v, input string tag);
        logic [DIGITS*7-1:0] exp_s;
        exp_s = pattern(v);
        n_chk++;
        if (seg_o !== exp_s) begin
            n_bad++;
            $display("FAIL %s: seg_o=%h expected=%h (value %0d)", tag, seg_o, exp_s, v);
        end
    endtask

    task automatic cyc(input bit k1, input bit k2, input string tag);
        key_start = k1; key_lap = k2;
        @(posedge clk);
        model_edge(k1, k2);
        @(negedge clk);
        check_val(m_lap ? m_frz : m_cnt, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, tag);
    endtask

    task automatic press(input bit k1, input bit k2, input int hold, input string tag);
        for (int i = 0; i < hold; i++) cyc(k1, k2, tag);
        cyc(1'b0, 1'b0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(60000 * 10);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int shown_before;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_val(0, "R1 reset state");
        idle(12, "R1 idle hold");

        // start, run, compare with closed form
        press(1, 0, 4, "R4 start press");
        idle(200, "R3 running");
        // start edge + 4 hold edges: running edges = hold-1 + 1 + 200 = 204
        n_chk++;
        if (m_cnt != (204 * TICK_HZ) / CLK_HZ) begin
            n_bad++;
            $display("FAIL R3: model=%0d expected=%0d", m_cnt, (204 * TICK_HZ) / CLK_HZ);
        end

        // lap freeze while running
        shown_before = m_cnt;
        press(0, 1, 3, "R6 lap freeze");
        n_chk++;
        if (m_frz != shown_before) begin
            n_bad++;
            $display("FAIL R6: frozen=%0d expected=%0d", m_frz, shown_before);
        end
        idle(90, "R6 frozen while counting");
        press(0, 1, 2, "R6 lap release");
        idle(40, "R6 live again");

        // stop and hold
        press(1, 0, 5, "R4 stop");
        idle(50, "R5 stopped hold");
        press(1, 0, 1, "R5 restart");
        idle(61, "R5 accumulate");

        // frozen through stop/start
        press(0, 1, 1, "R8 freeze");
        idle(11, "R8 frozen run");
        press(1, 0, 2, "R8 stop while frozen");
        idle(20, "R8 stopped frozen");
        press(1, 0, 2, "R8 start while frozen");
        idle(25, "R8 running frozen");
        press(1, 0, 1, "R8 stop again");
        press(0, 1, 1, "R7 clear from frozen");
        idle(5, "R7 cleared");

        // ties
        press(1, 0, 1, "R9 start");
        idle(17, "R9 run");
        press(1, 1, 3, "R9 tie stops");
        idle(10, "R9 stopped after tie");
        press(1, 1, 2, "R9 tie starts");
        idle(13, "R9 running after tie");
        press(0, 1, 1, "R9 freeze");
        press(1, 1, 1, "R9 tie while frozen");
        idle(9, "R9 still frozen");
        press(1, 1, 1, "R9 tie restarts frozen");
        press(0, 1, 1, "R6 unfreeze");
        press(1, 0, 1, "R4 stop");
        press(0, 1, 4, "R7 clear from live");
        idle(3, "R7 cleared live");
        press(0, 1, 1, "R7 clear when already zero");

        // long run through all digit values and the wrap
        press(1, 0, 30, "R4 long hold start");
        idle(23400, "R2 R11 R10 sweep and wrap");
        n_chk++;
        if (m_cnt >= 100) begin
            n_bad++;
            $display("FAIL R10: model count=%0d expected below 100 after wrap", m_cnt);
        end
        press(1, 0, 1, "R4 final stop");
        idle(10, "R5 final hold");
        finish_run();
    end
endmodule